// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is a two-wire serial slave that puts a byte-addressed memory of 256 or 512 bytes on a shared I2C bus. The SCL and SDA lines are sampled in the fast system clock domain, which sees every bus edge as a single-cycle event. The slave answers to a device byte that carries a fixed family code and values set by strap pins. It takes a byte address, then either stores data bytes or returns bytes from an internal address counter. It pulls SDA low through an open-drain enable and never drives it high.

Written bytes first collect in a page staging block of 16 bytes. That block copies them into the array during a fixed write cycle after STOP. While the cycle runs, the slave gives no acknowledge to its own device byte, so a master can poll until the memory is free. Reads can start at the current counter, at an address set by a write header with no data, or run on across many bytes.

Top module: `i2cm_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and every memory byte reads back as 0xFF.
- R2: A falling SDA while SCL is high starts a new transaction from any state, and a rising SDA while SCL is high returns the slave to idle. A repeated START with no STOP between is accepted.
- R3: The device byte's bits 7..4 must be 1010. With 256 bytes, bits 3..1 must equal `strap_i[2:0]`. With 512 bytes, bits 3..2 must equal `strap_i[2:1]` and bit 1 supplies memory address bit 8. Bit 0 set means read. On a mismatch the slave gives no acknowledge and ignores the bus until the next START.
- R4: The slave pulls SDA low for the whole 9th clock after a matching device byte and after each address or data byte it receives.
- R5: `sda_oe` changes only while SCL is low. Input bits are taken on rising SCL.
- R6: A device byte with bit 0 clear, an address byte, one data byte and STOP store that byte at that address once the write cycle ends.
- R7: Consecutive data bytes go to consecutive addresses within one 16-byte page. Bits 3..0 of the address wrap, so that bytes past the 16th overwrite earlier ones. Other pages are not touched.
- R8: For WR_CYCLES clocks after a STOP that ends a write with data, the slave does not acknowledge its device byte.
- R9: A write header with an address and no data, followed by a repeated START and a read device byte, returns the byte at that address.
- R10: A read device byte with no address first returns the byte at the internal counter. The counter holds one past the last byte read.
- R11: Each master ACK makes the slave send the byte at the next address. After the top address it continues at address 0.
- R12: After a master NACK the slave releases SDA and stays silent until the next START.
- R13: A STOP after an address byte with no data starts no write cycle and changes no memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Board-level device select straps |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong bit counter or state shows up within the same byte as an acknowledge in the wrong bit slot, or as data shifted by one position. A stale internal address counter goes unseen until the next read that has no address first, which then returns the byte from the wrong location. A write-cycle tracker that gets stuck appears one transaction later, as a refused device byte that never recovers, or as data read back at its old value.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam logic [3:0] FAMILY_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_WADDR,
        S_WDATA,
        S_TX,
        S_MACK
    } cmd_st_t;

endpackage

// File: rtl/i2cm_front.sv
module i2cm_front (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_q    <= scl_sync[1];
            sda_q    <= sda_sync[1];
        end
    end

    assign scl_s    = scl_sync[1];
    assign sda_s    = sda_sync[1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
    parameter int A_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [A_W-1:0] waddr,
    input  logic [7:0]     wdata,
    input  logic [A_W-1:0] raddr,
    output logic [7:0]     rdata
);
    localparam int DEPTH = 1 << A_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2cm_wrbuf.sv
module i2cm_wrbuf #(
    parameter int A_W       = 8,
    parameter int PAGE      = 16,
    parameter int WR_CYCLES = 1500
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           push,
    input  logic [A_W-1:0] push_addr,
    input  logic [7:0]     push_data,
    input  logic           commit,
    output logic           busy,
    output logic           mem_we,
    output logic [A_W-1:0] mem_waddr,
    output logic [7:0]     mem_wdata
);
    localparam int PG_W = $clog2(PAGE);
    localparam int CW   = $clog2(WR_CYCLES + 1);

    logic [7:0]          slot [PAGE];
    logic [PAGE-1:0]     mask;
    logic [A_W-PG_W-1:0] base;
    logic [CW-1:0]       cnt;
    logic [PG_W-1:0]     drain_idx;
    logic                draining;

    assign drain_idx = cnt[PG_W-1:0];
    assign draining  = busy && (cnt < CW'(PAGE));

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            base <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (busy) begin
            if (cnt == CW'(WR_CYCLES - 1)) begin
                busy <= 1'b0;
                mask <= '0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (commit && |mask) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (clear || commit) begin
            mask <= '0;
        end else if (push) begin
            if (mask == '0) base <= push_addr[A_W-1:PG_W];
            mask[push_addr[PG_W-1:0]] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !busy) slot[push_addr[PG_W-1:0]] <= push_data;
    end

    assign mem_we    = draining && mask[drain_idx];
    assign mem_waddr = {base, drain_idx};
    assign mem_wdata = slot[drain_idx];

    // R8
    push_idle_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !busy);

    // R7
    same_page_chk: assert property (@(posedge clk) disable iff (rst)
        (push && |mask) |-> (push_addr[A_W-1:PG_W] == base));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(WR_CYCLES)));
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
    import i2cm_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int PAGE      = 16,
    parameter int WR_CYCLES = 1500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe
);
    localparam int A_W = $clog2(MEM_BYTES);
    localparam logic [A_W-1:0] PG_MASK = A_W'(PAGE - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    cmd_st_t        st;
    logic [3:0]     bitcnt;
    logic [7:0]     shreg, txb;
    logic           ack_ph, is_rd, mack;
    logic [A_W-1:0] ptr, waddr_full, ptr_pg_next;
    logic           dev_match, dev_ok, byte_done, rx_state;
    logic           wb_push, wb_commit, wr_busy;
    logic           mem_we;
    logic [A_W-1:0] mem_waddr;
    logic [7:0]     mem_wdata, mem_rdata;

    i2cm_front u_front (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    generate
        if (A_W > 8) begin : g_hi
            logic a8_q;
            always_ff @(posedge clk) begin
                if (rst) a8_q <= 1'b0;
                else if (byte_done && st == S_DEV && dev_ok && !shreg[0]) a8_q <= shreg[1];
            end
            assign waddr_full = {a8_q, shreg};
            assign dev_match  = (shreg[7:4] == FAMILY_CODE) && (shreg[3:2] == strap_i[2:1]);
        end else begin : g_lo
            assign waddr_full = shreg;
            assign dev_match  = (shreg[7:4] == FAMILY_CODE) && (shreg[3:1] == strap_i);
        end
    endgenerate

    assign rx_state    = (st == S_DEV) || (st == S_WADDR) || (st == S_WDATA);
    assign byte_done   = rx_state && !ack_ph && scl_fall && (bitcnt == 4'd8);
    assign dev_ok      = dev_match && !wr_busy;
    assign ptr_pg_next = (ptr & ~PG_MASK) | ((ptr + 1'b1) & PG_MASK);
    assign wb_push     = byte_done && (st == S_WDATA);
    assign wb_commit   = stop_ev && (st == S_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txb    <= '0;
            sda_oe <= 1'b0;
            ack_ph <= 1'b0;
            is_rd  <= 1'b0;
            mack   <= 1'b0;
            ptr    <= '0;
        end else if (start_ev) begin
            st     <= S_DEV;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            st     <= S_IDLE;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (!ack_ph) begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            if (st == S_DEV) begin
                                if (dev_ok) begin
                                    ack_ph <= 1'b1;
                                    sda_oe <= 1'b1;
                                    is_rd  <= shreg[0];
                                end else begin
                                    st <= S_IDLE;
                                end
                            end else begin
                                ack_ph <= 1'b1;
                                sda_oe <= 1'b1;
                                ptr    <= (st == S_WADDR) ? waddr_full : ptr_pg_next;
                            end
                        end
                    end else if (scl_fall) begin
                        ack_ph <= 1'b0;
                        bitcnt <= '0;
                        if (st == S_DEV && is_rd) begin
                            st     <= S_TX;
                            txb    <= mem_rdata;
                            sda_oe <= ~mem_rdata[7];
                            ptr    <= ptr + 1'b1;
                            bitcnt <= 4'd1;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= (st == S_DEV) ? S_WADDR : S_WDATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (bitcnt != 4'd8) begin
                            sda_oe <= ~txb[~bitcnt[2:0]];
                            bitcnt <= bitcnt + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= S_MACK;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            st     <= S_TX;
                            txb    <= mem_rdata;
                            sda_oe <= ~mem_rdata[7];
                            ptr    <= ptr + 1'b1;
                            bitcnt <= 4'd1;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    i2cm_wrbuf #(.A_W(A_W), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_wrbuf (
        .clk(clk), .rst(rst), .clear(start_ev),
        .push(wb_push), .push_addr(ptr), .push_data(shreg),
        .commit(wb_commit), .busy(wr_busy),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    i2cm_mem #(.A_W(A_W)) u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(ptr), .rdata(mem_rdata)
    );

    // R5
    oe_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R4
    oe_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && st != S_TX) |-> ack_ph);

    // R12
    mack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_MACK) |-> !sda_oe);

    // R3
    nomatch_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && st == S_DEV && !dev_match) |=> !sda_oe);

    // R10
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_MACK && scl_fall && mack) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: tb/test_i2cm_slave.sv
module test_i2cm_slave;
    localparam int Q = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    // kind[17:16] (0 write, 1 random read), addr[15:8], data[7:0]
    localparam logic [17:0] VEC [10] = '{
        {2'd0, 8'h10, 8'hA5}, {2'd0, 8'h11, 8'h3C}, {2'd0, 8'h01, 8'h77},
        {2'd0, 8'h02, 8'h00}, {2'd0, 8'hFF, 8'h5A}, {2'd1, 8'h10, 8'hA5},
        {2'd1, 8'h11, 8'h3C}, {2'd1, 8'hFF, 8'h5A}, {2'd1, 8'h01, 8'h77},
        {2'd1, 8'h40, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int r5_viol = 0;
    logic [7:0] model [256];
    logic [7:0] rbuf [16];

    always #5 clk = ~clk;

    i2cm_slave i_i2cm_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .strap_i(STRAP), .sda_oe(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl = 1'b1;   tick(Q);
            s1 = sda_line; tick(Q);
            s2 = sda_line;
            b[i] = s1;
            if (s1 != s2) r5_viol++;
            scl = 1'b0;   tick(Q);
        end
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1;   tick(2 * Q);
        scl = 1'b0;   tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic wait_ready(output int polls);
        bit ack;
        polls = 0;
        do begin
            bus_start();
            send_byte(DEV_W, ack);
            bus_stop();
            polls++;
        end while (!ack && polls < 100);
        chk(ack, "R8 ready after write cycle", polls, 0);
    endtask

    task automatic write_bytes(input logic [7:0] addr, input int n, input logic [7:0] d0, input bit wait_done);
        bit ack;
        int p;
        bus_start();
        send_byte(DEV_W, ack); chk(ack, "R4 device ack", ack, 1);
        send_byte(addr, ack);  chk(ack, "R4 address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            send_byte(d0 + 8'(i), ack);
            chk(ack, "R4 data ack", ack, 1);
            a = {addr[7:4], 4'(addr[3:0] + 4'(i))};
            model[a] = d0 + 8'(i);
        end
        bus_stop();
        if (wait_done) wait_ready(p);
    endtask

    task automatic read_from(input logic [7:0] addr, input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(DEV_W, ack); chk(ack, "R9 device ack", ack, 1);
        send_byte(addr, ack);  chk(ack, "R9 address ack", ack, 1);
        bus_start();
        send_byte(DEV_R, ack); chk(ack, "R2 repeated start read ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ack;
        int p;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        read_from(8'h00, 1);
        chk(rbuf[0] == 8'hFF, "R1 erased byte", rbuf[0], 8'hFF);

        // table of writes and random reads (R6, R9)
        for (int v = 0; v < 10; v++) begin
            if (VEC[v][17:16] == 2'd0) begin
                write_bytes(VEC[v][15:8], 1, VEC[v][7:0], 1'b1);
            end else begin
                read_from(VEC[v][15:8], 1);
                chk(rbuf[0] == VEC[v][7:0], "R6 R9 random read", rbuf[0], VEC[v][7:0]);
            end
        end

        // R3 wrong family code and wrong straps
        bus_start(); send_byte(8'hBA, ack); bus_stop();
        chk(!ack, "R3 wrong family code", ack, 0);
        bus_start(); send_byte(8'hA0, ack); bus_stop();
        chk(!ack, "R3 strap mismatch", ack, 0);

        // R8 busy refusal, then R6 data landed
        write_bytes(8'h33, 1, 8'h99, 1'b0);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        chk(!ack, "R8 refused while busy", ack, 0);
        wait_ready(p);
        read_from(8'h33, 1);
        chk(rbuf[0] == 8'h99, "R6 byte after write cycle", rbuf[0], 8'h99);

        // R13 address only, then STOP
        bus_start(); send_byte(DEV_W, ack); send_byte(8'h50, ack); bus_stop();
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        chk(ack, "R13 no write cycle after address only", ack, 1);
        read_from(8'h50, 1);
        chk(rbuf[0] == 8'hFF, "R13 byte unchanged", rbuf[0], 8'hFF);

        // R7 page write with wrap, checked by a sequential read
        write_bytes(8'h2E, 18, 8'h40, 1'b1);
        read_from(8'h20, 16);
        for (int i = 0; i < 16; i++)
            chk(rbuf[i] == model[8'h20 + i], "R7 R11 page content", rbuf[i], model[8'h20 + i]);
        chk(model[8'h2E] == 8'h50, "R7 bench wrap model", model[8'h2E], 8'h50);
        read_from(8'h30, 1);
        chk(rbuf[0] == 8'hFF, "R7 next page untouched", rbuf[0], 8'hFF);

        // R11 wrap from top address to 0
        read_from(8'hFE, 3);
        chk(rbuf[0] == 8'hFF, "R11 byte FE", rbuf[0], 8'hFF);
        chk(rbuf[1] == 8'h5A, "R11 byte FF", rbuf[1], 8'h5A);
        chk(rbuf[2] == 8'hFF, "R11 wrapped to 00", rbuf[2], 8'hFF);

        // R12 silent after master NACK (fresh read, extra byte clocked without START)
        bus_start(); send_byte(DEV_W, ack); send_byte(8'hFF, ack);
        bus_start(); send_byte(DEV_R, ack);
        recv_byte(1'b0, b);
        chk(b == 8'h5A, "R12 byte before NACK", b, 8'h5A);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R12 line released after NACK", b, 8'hFF);
        bus_stop();

        // R10 current-address read continues one past the last byte read
        bus_start(); send_byte(DEV_R, ack); recv_byte(1'b0, b); bus_stop();
        chk(ack, "R10 read device ack", ack, 1);
        chk(b == 8'hFF, "R10 current address 00", b, 8'hFF);
        bus_start(); send_byte(DEV_R, ack); recv_byte(1'b0, b); bus_stop();
        chk(b == 8'h77, "R10 current address 01", b, 8'h77);

        // R5 SDA held steady while SCL high in every read bit
        chk(r5_viol == 0, "R5 sda stable while scl high", r5_viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule